// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block walks a ring of receive buffer descriptors kept in system memory for an Ethernet receive path. Each descriptor takes two 32-bit words. The word at byte offset 0 carries a 16-bit status halfword in bits 31:16 and a 16-bit length in bits 15:0. The word at offset 4 holds the 32-bit buffer address. The engine reads descriptors through a single-beat memory master port. It gives each owned buffer to an external data mover together with a byte count. When the move completes, it writes the first descriptor word back. That write returns ownership to software and records the bytes used and, on the final buffer of a frame, the frame status.

Software builds the ring and marks each descriptor it hands over as empty. It programs the ring base and the per-buffer capacity, sets the enable input, and pulses the doorbell input. The received data is modelled as a stream of chunks. Each chunk carries a byte count, an end-of-frame marker and nine status flags. A chunk larger than the buffer capacity is spread over consecutive descriptors. If the engine meets a descriptor that software still owns, it parks. It then waits for the doorbell, and it discards any chunk that arrives while it is parked.

Top module: `rxbd_ring_engine`

## Requirements
- R1: Descriptor layout. The status halfword is bits 31:16 of the word at the descriptor address and the length is bits 15:0. The buffer address is the word at descriptor address + 4. Within the status halfword, bit 15 is empty (owned by hardware), bit 13 is wrap and bit 11 is last-in-frame.
- R2: A fetched descriptor whose empty bit is 0 stops the engine, and it makes no further memory request until a doorbell pulse. While it is stopped, every incoming chunk is accepted at once and discarded, the single-cycle `rx_drop` pulse is raised, and memory is not written.
- R3: A doorbell pulse while the engine is stopped makes it fetch the same descriptor again. A doorbell that arrives during a fetch which then finds the empty bit clear causes one immediate refetch.
- R4: For an owned descriptor, `dm_start` is raised with `dm_addr` equal to the buffer address and `dm_len` equal to the smaller of the remaining chunk bytes and `cfg_buf_bytes`.
- R5: Write-back clears bit 15 and writes the length field with the bytes placed in that buffer. It keeps status bits 14, 13, 12, 10 and 9 as fetched.
- R6: Bit 11 is written as 1 only on the buffer that holds the final byte of a chunk marked end-of-frame. On that buffer only, status bits 8:0 are replaced by `chunk_flags[8:0]`. On every other buffer, bits 8:0 keep their fetched values.
- R7: After a write-back, the next descriptor is at the ring base if the wrap bit was set, and at the current address + 8 otherwise.
- R8: While `cfg_enable` is 0, no memory request is made, descriptor memory is untouched, and the current pointer follows the ring base. After enable returns, fetching starts at the ring base only on a doorbell.
- R9: Bits 2:0 of `cfg_ring_base` are ignored, so the ring always starts on an 8-byte boundary.
- R10: `irq_buf` pulses for one cycle after each descriptor write-back. `irq_frame` pulses in the same cycle when that write-back set bit 11.
- R11: A chunk larger than `cfg_buf_bytes` fills consecutive descriptors with full buffers, and the remainder goes into the following descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Engine enable; low resets the ring walk |
| cfg_ring_base | input | ADDR_W | Ring start address (low 3 bits ignored) |
| cfg_buf_bytes | input | 16 | Capacity of every receive buffer in bytes |
| doorbell | input | 1 | One-cycle pulse: new empty descriptors available |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current access |
| chunk_valid | input | 1 | A received chunk is offered |
| chunk_ready | output | 1 | Chunk accepted in this cycle when valid |
| chunk_bytes | input | 16 | Byte count of the chunk |
| chunk_eof | input | 1 | Chunk ends a frame |
| chunk_flags | input | 9 | Frame status flags for status bits 8:0 |
| dm_start | output | 1 | One-cycle request to move data into a buffer |
| dm_addr | output | 32 | Buffer address for the move |
| dm_len | output | 16 | Bytes to move |
| dm_done | input | 1 | One-cycle completion of the move |
| irq_buf | output | 1 | Buffer written back |
| irq_frame | output | 1 | Last buffer of a frame written back |
| rx_drop | output | 1 | Chunk discarded because no descriptor was owned |

## Verification
The assertions rely on the following input behaviour:
- The memory answers each request with exactly one `mem_ack`, and that ack comes no earlier than the cycle after the request appears.
- `dm_done` comes only after `dm_start`.
- `cfg_buf_bytes` is nonzero.
- The ring base is changed only while the engine is disabled.

The bench memory model acks one cycle after it sees a request. The mover model answers two cycles after each start. The bench writes the ring base and descriptor contents only while the engine is parked or disabled.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  // status halfword bit positions (neighbouring software decodes these)
  localparam int ST_OWN  = 15;
  localparam int ST_WRAP = 13;
  localparam int ST_LAST = 11;
  localparam int FLAG_W  = 9;
  localparam int LEN_W   = 16;
  localparam int WORD_W  = 32;
  localparam int DESC_BYTES = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_WAIT, S_MOVE, S_WB
  } rx_state_t;
endpackage

// File: rtl/rxbd_addr_gen.sv
module rxbd_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] base,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] cur
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(rxbd_pkg::DESC_BYTES - 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(rxbd_pkg::DESC_BYTES);

  logic [ADDR_W-1:0] base_al;
  logic [ADDR_W-1:0] cur_n;

  assign base_al = base & ALIGN_MASK;

  always_comb begin
    cur_n = cur;
    if (!enable)      cur_n = base_al;
    else if (advance) cur_n = wrap ? base_al : cur + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= cur_n;
  end
endmodule

// File: rtl/rxbd_wb_fmt.sv
module rxbd_wb_fmt
  import rxbd_pkg::*;
(
  input  logic [15:0]       st_in,
  input  logic              last,
  input  logic [FLAG_W-1:0] flags,
  input  logic [LEN_W-1:0]  used,
  output logic [WORD_W-1:0] word
);
  logic [15:0] st_out;

  always_comb begin
    st_out         = st_in;
    st_out[ST_OWN] = 1'b0;
    st_out[ST_LAST] = last;
    if (last) st_out[FLAG_W-1:0] = flags;
    word = {st_out, used};
  end
endmodule

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl
  import rxbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              doorbell,
  input  logic [LEN_W-1:0]  buf_bytes,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic              sel_second,
  input  logic              chunk_valid,
  output logic              chunk_ready,
  input  logic [LEN_W-1:0]  chunk_bytes,
  input  logic              chunk_eof,
  input  logic [FLAG_W-1:0] chunk_flags,
  output logic              dm_start,
  output logic [WORD_W-1:0] dm_addr,
  output logic [LEN_W-1:0]  dm_len,
  input  logic              dm_done,
  output logic              advance,
  output logic              wrap,
  output logic [15:0]       st_q_o,
  output logic              wb_last,
  output logic [FLAG_W-1:0] flags_o,
  output logic [LEN_W-1:0]  used_o,
  output logic              irq_buf,
  output logic              irq_frame,
  output logic              rx_drop
);
  rx_state_t         state, state_n;
  logic              db_q, db_n;
  logic [15:0]       st_q, st_n;
  logic [WORD_W-1:0] ptr_q, ptr_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [LEN_W-1:0]  used_q, used_n, used_c;
  logic              eof_q, eof_n;
  logic [FLAG_W-1:0] flg_q, flg_n;
  logic              have_q, have_n;
  logic              wb_done, drop_c;

  assign used_c  = (rem_q > buf_bytes) ? buf_bytes : rem_q;
  assign wb_last = eof_q && (rem_q == used_q);

  assign mem_req    = (state == S_RD0) || (state == S_RD1) || (state == S_WB);
  assign mem_we     = (state == S_WB);
  assign sel_second = (state == S_RD1);
  assign chunk_ready = (state == S_IDLE) || ((state == S_WAIT) && !have_q);
  assign dm_start   = enable && (state == S_WAIT) && have_q;
  assign dm_addr    = ptr_q;
  assign dm_len     = used_c;
  assign wrap       = st_q[ST_WRAP];
  assign st_q_o     = st_q;
  assign flags_o    = flg_q;
  assign used_o     = used_q;
  assign drop_c     = chunk_valid && (state == S_IDLE);

  always_comb begin
    state_n = state;
    db_n    = db_q | (doorbell & enable);
    st_n    = st_q;
    ptr_n   = ptr_q;
    rem_n   = rem_q;
    used_n  = used_q;
    eof_n   = eof_q;
    flg_n   = flg_q;
    have_n  = have_q;
    advance = 1'b0;
    wb_done = 1'b0;
    if (!enable) begin
      state_n = S_IDLE;
      db_n    = 1'b0;
      have_n  = 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (db_q || doorbell) begin
            state_n = S_RD0;
            db_n    = 1'b0;
          end
        end
        S_RD0: begin
          if (mem_ack) begin
            if (mem_rdata[16 + ST_OWN]) begin
              st_n    = mem_rdata[WORD_W-1:16];
              state_n = S_RD1;
            end else if (db_q || doorbell) begin
              db_n    = 1'b0;
            end else begin
              state_n = S_IDLE;
            end
          end
        end
        S_RD1: begin
          if (mem_ack) begin
            ptr_n   = mem_rdata;
            state_n = S_WAIT;
          end
        end
        S_WAIT: begin
          if (have_q) begin
            used_n  = used_c;
            state_n = S_MOVE;
          end else if (chunk_valid) begin
            rem_n  = chunk_bytes;
            eof_n  = chunk_eof;
            flg_n  = chunk_flags;
            have_n = 1'b1;
          end
        end
        S_MOVE: begin
          if (dm_done) state_n = S_WB;
        end
        S_WB: begin
          if (mem_ack) begin
            rem_n   = rem_q - used_q;
            have_n  = (rem_q != used_q);
            advance = 1'b1;
            wb_done = 1'b1;
            db_n    = 1'b0;
            state_n = S_RD0;
          end
        end
        default: state_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      db_q      <= 1'b0;
      st_q      <= '0;
      ptr_q     <= '0;
      rem_q     <= '0;
      used_q    <= '0;
      eof_q     <= 1'b0;
      flg_q     <= '0;
      have_q    <= 1'b0;
      irq_buf   <= 1'b0;
      irq_frame <= 1'b0;
      rx_drop   <= 1'b0;
    end else begin
      state     <= state_n;
      db_q      <= db_n;
      st_q      <= st_n;
      ptr_q     <= ptr_n;
      rem_q     <= rem_n;
      used_q    <= used_n;
      eof_q     <= eof_n;
      flg_q     <= flg_n;
      have_q    <= have_n;
      irq_buf   <= wb_done;
      irq_frame <= wb_done && wb_last;
      rx_drop   <= drop_c;
    end
  end
endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [15:0]       cfg_buf_bytes,
  input  logic              doorbell,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  input  logic              chunk_valid,
  output logic              chunk_ready,
  input  logic [15:0]       chunk_bytes,
  input  logic              chunk_eof,
  input  logic [8:0]        chunk_flags,
  output logic              dm_start,
  output logic [31:0]       dm_addr,
  output logic [15:0]       dm_len,
  input  logic              dm_done,
  output logic              irq_buf,
  output logic              irq_frame,
  output logic              rx_drop
);
  localparam logic [ADDR_W-1:0] PTR_OFS = ADDR_W'(4);

  logic [1:0]        rst_sync;
  logic              rst_n_i;
  logic [ADDR_W-1:0] cur;
  logic              advance, wrap, sel_second, wb_last;
  logic [15:0]       st_q;
  logic [FLAG_W-1:0] flg_q;
  logic [LEN_W-1:0]  used_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  rxbd_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n_i), .enable(cfg_enable), .base(cfg_ring_base),
    .advance(advance), .wrap(wrap), .cur(cur)
  );

  rxbd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .enable(cfg_enable), .doorbell(doorbell),
    .buf_bytes(cfg_buf_bytes), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_we(mem_we), .sel_second(sel_second),
    .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
    .chunk_bytes(chunk_bytes), .chunk_eof(chunk_eof), .chunk_flags(chunk_flags),
    .dm_start(dm_start), .dm_addr(dm_addr), .dm_len(dm_len), .dm_done(dm_done),
    .advance(advance), .wrap(wrap), .st_q_o(st_q), .wb_last(wb_last),
    .flags_o(flg_q), .used_o(used_q),
    .irq_buf(irq_buf), .irq_frame(irq_frame), .rx_drop(rx_drop)
  );

  rxbd_wb_fmt u_fmt (
    .st_in(st_q), .last(wb_last), .flags(flg_q), .used(used_q), .word(mem_wdata)
  );

  assign mem_addr = sel_second ? cur + PTR_OFS : cur;
endmodule

// File: rtl/rxbd_ring_engine_chk.sv
module rxbd_ring_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic [15:0]       cfg_buf_bytes,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              dm_start,
  input logic [15:0]       dm_len,
  input logic              irq_buf,
  input logic              irq_frame
);
  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !mem_req);

  // R9
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && cfg_enable) |=> (mem_req && $stable(mem_addr)));

  // R5
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  // R10
  frame_has_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frame |-> irq_buf);

  // R10
  buf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_buf |=> !irq_buf);

  // R4
  dm_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_start |-> dm_len <= cfg_buf_bytes);
endmodule

bind rxbd_ring_engine rxbd_ring_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_buf_bytes(cfg_buf_bytes),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .dm_start(dm_start), .dm_len(dm_len),
  .irq_buf(irq_buf), .irq_frame(irq_frame)
);

// File: tb/rxbd_ring_engine_test.sv
`timescale 1ns/1ps
module rxbd_ring_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [31:0] cfg_ring_base = 32'h100;
  logic [15:0] cfg_buf_bytes = 16'd64;
  logic        doorbell = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        chunk_valid = 1'b0;
  logic        chunk_ready;
  logic [15:0] chunk_bytes = '0;
  logic        chunk_eof = 1'b0;
  logic [8:0]  chunk_flags = '0;
  logic        dm_start;
  logic [31:0] dm_addr;
  logic [15:0] dm_len;
  logic        dm_done = 1'b0;
  logic        irq_buf, irq_frame, rx_drop;

  int total = 0, failed = 0;
  int n_buf = 0, n_frame = 0, n_drop = 0, n_req = 0;
  logic [31:0] last_dm_addr;
  logic [15:0] last_dm_len;
  logic        arm_first = 1'b0;
  logic [31:0] first_addr = '0;
  int          dm_cnt = 0;
  logic [31:0] mem [0:255];

  always #10 clk = ~clk;  // 50 MHz

  rxbd_ring_engine uut (.*);

  // memory model: ack one cycle after request
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      n_req   = n_req + 1;
      if (arm_first) begin first_addr = mem_addr; arm_first = 1'b0; end
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:2]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // data mover model and event counters
  always @(posedge clk) begin
    dm_done <= 1'b0;
    if (dm_start) begin
      last_dm_addr = dm_addr; last_dm_len = dm_len; dm_cnt = 2;
    end else if (dm_cnt != 0) begin
      dm_cnt = dm_cnt - 1;
      if (dm_cnt == 0) dm_done <= 1'b1;
    end
    if (irq_buf)   n_buf   = n_buf + 1;
    if (irq_frame) n_frame = n_frame + 1;
    if (rx_drop)   n_drop  = n_drop + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ring(input logic [31:0] a);
    @(negedge clk) doorbell = 1'b1;
    @(negedge clk) doorbell = 1'b0;
  endtask

  task automatic send(input int bytes, input logic eof, input logic [8:0] fl);
    @(negedge clk);
    chunk_valid = 1'b1; chunk_bytes = 16'(bytes); chunk_eof = eof; chunk_flags = fl;
    while (!chunk_ready) @(negedge clk);
    @(posedge clk); #1;
    chunk_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R8 reset mem_req", {31'b0, mem_req}, 32'd0);
    chk("R10 reset irq", {30'b0, irq_buf, irq_frame}, 32'd0);
    chk("R4 reset dm_start", {31'b0, dm_start}, 32'd0);
  endtask

  task automatic t_single;
    int b0, f0;
    b0 = n_buf; f0 = n_frame;
    cfg_enable = 1'b1;
    idle(2);
    ring(0);
    idle(20);
    send(60, 1'b1, 9'h1A5);
    idle(40);
    chk("R6 R5 single frame wb", mem[8'h40], 32'h09A5_003C);
    chk("R4 dm addr", last_dm_addr, 32'h1000_0000);
    chk("R4 dm len", {16'b0, last_dm_len}, 32'd60);
    chk("R10 irq_buf count", n_buf - b0, 1);
    chk("R10 irq_frame count", n_frame - f0, 1);
    chk("R1 pointer word kept", mem[8'h41], 32'h1000_0000);
  endtask

  task automatic t_span;
    int b0, f0;
    b0 = n_buf; f0 = n_frame;
    send(150, 1'b1, 9'h004);
    idle(60);
    chk("R11 R6 first full buffer", mem[8'h42], 32'h0003_0040);
    chk("R11 R5 wrap buffer", mem[8'h44], 32'h2000_0040);
    chk("R7 no fetch past wrap", mem[8'h46], 32'h8000_0000);
    chk("R2 stopped on owned-by-sw", mem[8'h40], 32'h09A5_003C);
    chk("R10 no frame yet", n_frame - f0, 0);
    mem[8'h40] = 32'h8000_0000;
    ring(0);
    idle(40);
    chk("R3 R11 remainder after doorbell", mem[8'h40], 32'h0804_0016);
    chk("R4 remainder len", {16'b0, last_dm_len}, 32'd22);
    chk("R10 buf count span", n_buf - b0, 3);
    chk("R10 frame count span", n_frame - f0, 1);
  endtask

  task automatic t_overrun;
    int d0, b0;
    d0 = n_drop; b0 = n_buf;
    send(30, 1'b1, 9'h001);
    idle(10);
    chk("R2 drop pulse", n_drop - d0, 1);
    chk("R2 no write-back", n_buf - b0, 0);
    chk("R2 descriptor untouched", mem[8'h42], 32'h0003_0040);
  endtask

  task automatic t_disable;
    int r0, f0;
    @(negedge clk) cfg_enable = 1'b0;
    cfg_ring_base = 32'h203;
    mem[8'h80] = 32'hA011_0000;
    mem[8'h81] = 32'h2000_0000;
    idle(4);
    cfg_enable = 1'b1;
    r0 = n_req;
    idle(10);
    chk("R8 no fetch before doorbell", n_req - r0, 0);
    arm_first = 1'b1;
    ring(0);
    idle(10);
    chk("R9 R8 first fetch at aligned base", first_addr, 32'h200);
    send(20, 1'b0, 9'h1FF);
    idle(40);
    chk("R6 non-last keeps flags", mem[8'h80], 32'h2011_0014);
    chk("R8 old ring untouched", mem[8'h42], 32'h0003_0040);
    f0 = n_frame;
    mem[8'h80] = 32'hA000_0000;
    ring(0);
    idle(10);
    send(10, 1'b1, 9'h002);
    idle(40);
    chk("R7 wrap to base, last flags", mem[8'h80], 32'h2802_000A);
    chk("R10 frame after wrap", n_frame - f0, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[8'h40] = 32'h8000_0000; mem[8'h41] = 32'h1000_0000;
    mem[8'h42] = 32'h8003_0000; mem[8'h43] = 32'h1000_0400;
    mem[8'h44] = 32'hA000_0000; mem[8'h45] = 32'h1000_0800;
    mem[8'h46] = 32'h8000_0000; mem[8'h47] = 32'h1000_0C00;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_single;
    t_span;
    t_overrun;
    t_disable;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule